// File: doc/BRIEF.md
# Strobe-Commanded GPIO Bank

This block controls a bank of up to eight general-purpose pins through a single 32-bit word on a simple register bus. Software does not write stored values. Each write carries one-shot command bits. For every pin there is a pair of bits that drives the pin low or high, and a second pair that makes the pin an output or an input. A bit written as zero does nothing. Two software threads that own different pins can therefore write the word without reading it first and without a lock.

A read of the same word reports each pin's level on an odd bit position. In input mode that level is the pad input after two synchronizer flops. In output mode it is the value the bank drives. The number of pins is a parameter. A four-pin bank uses only the low-order pin positions, and the bank ignores commands that name pins it does not have.

Top module: `gpio_pair_bank`

## Requirements
- R1: A write with bit 2n set drives the output value of pin n to 0 on the next clock edge.
- R2: A write with bit 2n+1 set drives the output value of pin n to 1 on the next clock edge.
- R3: A write with bit 2n+16 set makes pin n an output (output enable 1) on the next clock edge.
- R4: A write with bit 2n+17 set makes pin n an input (output enable 0) on the next clock edge.
- R5: Bits written as 0 leave the value and direction of their pin unchanged, so a write that names one pin leaves every other pin as it was.
- R6: When bits 2n and 2n+1 are both set in one write, pin n goes high. When bits 2n+16 and 2n+17 are both set, pin n becomes an input.
- R7: During reset and after it, every pin is an input with output value 0.
- R8: For an input pin n, read bit 2n+1 shows the pad level two clock edges after that level changes, and not one edge after.
- R9: For an output pin n, read bit 2n+1 shows the driven output value, whatever the pad input is.
- R10: Read bits other than 2n+1 for the configured pins are always 0. Command bits for pins at or beyond the configured pin count have no effect.
- R11: A write takes effect only when the write enable is high and the address equals the bank address. A read at any other address returns 0.
- R12: A pin switched to output after its value was written drives that value from the first cycle its output enable is 1.

Pins hold their value and direction until a later command changes them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_addr | input | ADDR_W | Word address for reads and writes |
| bus_we | input | 1 | Write enable; the write takes effect at the rising clock edge |
| bus_wdata | input | 32 | Command word |
| bus_rdata | output | 32 | Read word, combinational from the address |
| pad_in | input | PIN_COUNT | Pad input levels (asynchronous) |
| pad_out | output | PIN_COUNT | Output value per pin |
| pad_oe | output | PIN_COUNT | Output enable per pin |

## Verification
The bench sets both the low and high command bits, and both direction bits, for one pin in a single write. A design with the priority reversed would leave that pin low, or turn it into an output. It writes commands for one pin while another pin is already active. A design that rewrites a stored word would disturb the other pin, and a design that treats a zero bit as "clear" would reset it. It samples the synchronized read one edge and two edges after a pad change, and catches a synchronizer that has one flop too many or too few. A four-pin instance receives commands for the upper pins, and its read word is checked for stray bits. A design that ignored the pin count would move pins that do not exist or report them.

// File: rtl/gpio_pair_pkg.sv
package gpio_pair_pkg;

  localparam int WORD_W   = 32;
  localparam int PIN_MAX  = 8;
  localparam int DIR_BASE = 16;

  typedef struct packed {
    logic drive_lo;
    logic drive_hi;
    logic make_out;
    logic make_in;
  } pin_cmd_t;

  function automatic int lvl_lo_bit(input int n);
    return 2 * n;
  endfunction

  function automatic int lvl_hi_bit(input int n);
    return 2 * n + 1;
  endfunction

  function automatic int dir_out_bit(input int n);
    return DIR_BASE + 2 * n;
  endfunction

  function automatic int dir_in_bit(input int n);
    return DIR_BASE + 2 * n + 1;
  endfunction

endpackage

// File: rtl/gpio_cmd_decode.sv
module gpio_cmd_decode
  import gpio_pair_pkg::*;
#(
  parameter int                PIN_COUNT = 8,
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] BANK_ADDR = '0
) (
  input  logic [ADDR_W-1:0]                bus_addr,
  input  logic                             bus_we,
  input  logic [WORD_W-1:0]                bus_wdata,
  output gpio_pair_pkg::pin_cmd_t [PIN_COUNT-1:0] cmd_o
);

  logic wr_hit;
  logic unused_wdata;

  assign wr_hit       = bus_we && (bus_addr == BANK_ADDR);
  assign unused_wdata = ^bus_wdata;

  for (genvar p = 0; p < PIN_COUNT; p++) begin : g_pin
    always_comb begin
      cmd_o[p].drive_lo = wr_hit && bus_wdata[lvl_lo_bit(p)];
      cmd_o[p].drive_hi = wr_hit && bus_wdata[lvl_hi_bit(p)];
      cmd_o[p].make_out = wr_hit && bus_wdata[dir_out_bit(p)];
      cmd_o[p].make_in  = wr_hit && bus_wdata[dir_in_bit(p)];
    end
  end

endmodule

// File: rtl/gpio_pin_slice.sv
module gpio_pin_slice
  import gpio_pair_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  pin_cmd_t cmd_i,
  input  logic     pad_in_i,
  output logic     out_val_o,
  output logic     out_en_o,
  output logic     level_o
);

  logic val_q, val_d, val_ce;
  logic en_q,  en_d,  en_ce;
  logic sync_a_q, sync_b_q;

  // next state: high beats low, input beats output
  always_comb begin
    val_ce = cmd_i.drive_hi | cmd_i.drive_lo;
    val_d  = cmd_i.drive_hi;
    en_ce  = cmd_i.make_in | cmd_i.make_out;
    en_d   = !cmd_i.make_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= 1'b0;
      en_q  <= 1'b0;
    end else begin
      if (val_ce) val_q <= val_d;
      if (en_ce)  en_q  <= en_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_a_q <= 1'b0;
      sync_b_q <= 1'b0;
    end else begin
      sync_a_q <= pad_in_i;
      sync_b_q <= sync_a_q;
    end
  end

  assign out_val_o = val_q;
  assign out_en_o  = en_q;
  assign level_o   = en_q ? val_q : sync_b_q;

endmodule

// File: rtl/gpio_read_assemble.sv
module gpio_read_assemble
  import gpio_pair_pkg::*;
#(
  parameter int                PIN_COUNT = 8,
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] BANK_ADDR = '0
) (
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [PIN_COUNT-1:0] level_i,
  output logic [WORD_W-1:0]    rdata_o
);

  logic [WORD_W-1:0] word;

  always_comb begin
    word = '0;
    for (int p = 0; p < PIN_COUNT; p++) begin
      word[lvl_hi_bit(p)] = level_i[p];
    end
  end

  assign rdata_o = (bus_addr == BANK_ADDR) ? word : '0;

endmodule

// File: rtl/gpio_pair_bank.sv
module gpio_pair_bank
  import gpio_pair_pkg::*;
#(
  parameter int                PIN_COUNT = 8,
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] BANK_ADDR = 8'h22
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_we,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  input  logic [PIN_COUNT-1:0] pad_in,
  output logic [PIN_COUNT-1:0] pad_out,
  output logic [PIN_COUNT-1:0] pad_oe
);

  logic rst_meta_q, rst_n_q;
  pin_cmd_t [PIN_COUNT-1:0] cmd;
  logic [PIN_COUNT-1:0] level;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_n_q    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_n_q    <= rst_meta_q;
    end
  end

  gpio_cmd_decode #(
    .PIN_COUNT(PIN_COUNT), .ADDR_W(ADDR_W), .BANK_ADDR(BANK_ADDR)
  ) u_decode (
    .bus_addr (bus_addr),
    .bus_we   (bus_we),
    .bus_wdata(bus_wdata),
    .cmd_o    (cmd)
  );

  for (genvar p = 0; p < PIN_COUNT; p++) begin : g_slice
    gpio_pin_slice u_slice (
      .clk      (clk),
      .rst_n    (rst_n_q),
      .cmd_i    (cmd[p]),
      .pad_in_i (pad_in[p]),
      .out_val_o(pad_out[p]),
      .out_en_o (pad_oe[p]),
      .level_o  (level[p])
    );
  end

  gpio_read_assemble #(
    .PIN_COUNT(PIN_COUNT), .ADDR_W(ADDR_W), .BANK_ADDR(BANK_ADDR)
  ) u_read (
    .bus_addr(bus_addr),
    .level_i (level),
    .rdata_o (bus_rdata)
  );

endmodule

// File: rtl/gpio_pair_bank_chk.sv
module gpio_pair_bank_chk
  import gpio_pair_pkg::*;
#(
  parameter int                PIN_COUNT = 8,
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] BANK_ADDR = '0
) (
  input logic                 clk,
  input logic                 rst_q,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic                 bus_we,
  input logic [31:0]          bus_wdata,
  input logic [31:0]          bus_rdata,
  input logic [PIN_COUNT-1:0] pad_out,
  input logic [PIN_COUNT-1:0] pad_oe
);

  logic        hit;
  logic [31:0] legal_rd;

  assign hit = bus_we && (bus_addr == BANK_ADDR);

  always_comb begin
    legal_rd = '0;
    for (int p = 0; p < PIN_COUNT; p++) legal_rd[lvl_hi_bit(p)] = 1'b1;
  end

  for (genvar p = 0; p < PIN_COUNT; p++) begin : g_chk
    assert_oe_rise_R3: assert property (@(posedge clk) disable iff (!rst_q)
      $rose(pad_oe[p]) |-> $past(hit && bus_wdata[dir_out_bit(p)]));
    assert_oe_fall_R4: assert property (@(posedge clk) disable iff (!rst_q)
      $fell(pad_oe[p]) |-> $past(hit && bus_wdata[dir_in_bit(p)]));
    assert_high_wins_R6: assert property (@(posedge clk) disable iff (!rst_q)
      (hit && bus_wdata[lvl_lo_bit(p)] && bus_wdata[lvl_hi_bit(p)]) |=> pad_out[p]);
    assert_input_wins_R6: assert property (@(posedge clk) disable iff (!rst_q)
      (hit && bus_wdata[dir_out_bit(p)] && bus_wdata[dir_in_bit(p)]) |=> !pad_oe[p]);
  end

  assert_idle_stable_R5: assert property (@(posedge clk) disable iff (!rst_q)
    !hit |=> ($stable(pad_out) && $stable(pad_oe)));
  assert_rd_clean_R10: assert property (@(posedge clk) disable iff (!rst_q)
    (bus_rdata & ~legal_rd) == '0);
  assert_rd_addr_R11: assert property (@(posedge clk) disable iff (!rst_q)
    (bus_addr != BANK_ADDR) |-> (bus_rdata == '0));

endmodule

bind gpio_pair_bank gpio_pair_bank_chk #(
  .PIN_COUNT(PIN_COUNT), .ADDR_W(ADDR_W), .BANK_ADDR(BANK_ADDR)
) u_chk (
  .clk      (clk),
  .rst_q    (rst_n_q),
  .bus_addr (bus_addr),
  .bus_we   (bus_we),
  .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata),
  .pad_out  (pad_out),
  .pad_oe   (pad_oe)
);

// File: tb/test_gpio_pair_bank.sv
module test_gpio_pair_bank;

  localparam logic [7:0] BANK = 8'h22;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = BANK;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] rd_w, rd_n;
  logic [7:0]  pin_w = '0, out_w, oe_w;
  logic [3:0]  pin_n = '0, out_n, oe_n;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  gpio_pair_bank #(.PIN_COUNT(8), .ADDR_W(8), .BANK_ADDR(BANK)) i_gpio_pair_bank (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(rd_w), .pad_in(pin_w),
    .pad_out(out_w), .pad_oe(oe_w)
  );

  gpio_pair_bank #(.PIN_COUNT(4), .ADDR_W(8), .BANK_ADDR(BANK)) i_gpio_pair_bank_narrow (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(rd_n), .pad_in(pin_n),
    .pad_out(out_n), .pad_oe(oe_n)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d, input logic [7:0] a = BANK, input logic we = 1'b1);
    @(negedge clk);
    bus_addr = a; bus_we = we; bus_wdata = d;
    @(negedge clk);
    bus_addr = BANK; bus_we = 1'b0; bus_wdata = '0;
    #1;
  endtask

  task automatic t_reset;
    check("R7 oe in reset", {24'h0, oe_w}, 32'h0);
    check("R7 out in reset", {24'h0, out_w}, 32'h0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    check("R7 oe after reset", {24'h0, oe_w}, 32'h0);
    check("R7 out after reset", {24'h0, out_w}, 32'h0);
    check("R7 read after reset", rd_w, 32'h0);
  endtask

  task automatic t_level;
    wr(32'h1 << 7);
    check("R2 pin3 high", {24'h0, out_w}, 32'h08);
    wr(32'h1 << 6);
    check("R1 pin3 low", {24'h0, out_w}, 32'h00);
  endtask

  task automatic t_direction;
    wr(32'h1 << 5);
    check("R12 value before dir", {24'h0, oe_w}, 32'h00);
    wr(32'h1 << 20);
    check("R3 pin2 output", {24'h0, oe_w}, 32'h04);
    check("R12 value driven at enable", {24'h0, out_w}, 32'h04);
    wr(32'h1 << 21);
    check("R4 pin2 input", {24'h0, oe_w}, 32'h00);
    wr(32'h1 << 4);
  endtask

  task automatic t_independent;
    wr((32'h1 << 1) | (32'h1 << 16) | (32'h1 << 15));
    wr(32'h1 << 14);
    check("R5 pin0 out kept", {24'h0, out_w}, 32'h01);
    check("R5 pin0 oe kept", {24'h0, oe_w}, 32'h01);
    wr(32'h0);
    check("R5 zero write out", {24'h0, out_w}, 32'h01);
    check("R5 zero write oe", {24'h0, oe_w}, 32'h01);
    wr((32'h1 << 0) | (32'h1 << 17));
  endtask

  task automatic t_both;
    wr(32'h3 << 8);
    check("R6 high wins", {24'h0, out_w}, 32'h10);
    wr(32'h1 << 24);
    check("R6 pin4 output first", {24'h0, oe_w}, 32'h10);
    wr(32'h3 << 24);
    check("R6 input wins", {24'h0, oe_w}, 32'h00);
    wr(32'h1 << 8);
  endtask

  task automatic t_sync;
    @(negedge clk);
    pin_w[5] = 1'b1;
    @(negedge clk); #1;
    check("R8 one edge not yet", {31'h0, rd_w[11]}, 32'h0);
    @(negedge clk); #1;
    check("R8 two edges visible", {31'h0, rd_w[11]}, 32'h1);
    pin_w[5] = 1'b0;
    repeat (2) @(negedge clk); #1;
    check("R8 low returns", {31'h0, rd_w[11]}, 32'h0);
  endtask

  task automatic t_outread;
    pin_w[1] = 1'b0;
    wr((32'h1 << 3) | (32'h1 << 18));
    repeat (2) @(negedge clk); #1;
    check("R9 driven high read", {31'h0, rd_w[3]}, 32'h1);
    pin_w[1] = 1'b1;
    wr(32'h1 << 2);
    repeat (2) @(negedge clk); #1;
    check("R9 driven low read", {31'h0, rd_w[3]}, 32'h0);
    wr(32'h1 << 19);
    pin_w[1] = 1'b0;
  endtask

  task automatic t_addr;
    wr(32'h1 << 13, 8'h23, 1'b1);
    check("R11 wrong address write", {24'h0, out_w}, 32'h00);
    wr(32'h1 << 13, BANK, 1'b0);
    check("R11 no enable write", {24'h0, out_w}, 32'h00);
    pin_w = 8'hFF;
    repeat (3) @(negedge clk);
    bus_addr = 8'h21; #1;
    check("R11 wrong address read", rd_w, 32'h0);
    bus_addr = BANK; #1;
  endtask

  task automatic t_mask;
    wr(32'hFFFF_0000);
    pin_n = 4'hF;
    repeat (3) @(negedge clk); #1;
    check("R10 wide read bits", rd_w, 32'h0000_AAAA);
    check("R10 narrow read bits", rd_n, 32'h0000_00AA);
    wr(32'hFF00_FF00);
    check("R10 narrow upper cmds ignored out", {28'h0, out_n}, 32'h0);
    check("R10 narrow upper cmds ignored oe", {28'h0, oe_n}, 32'h0);
    check("R10 narrow read after upper cmds", rd_n, 32'h0000_00AA);
  endtask

  initial begin
    #(20 * 100000);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #3;
    t_reset;
    t_level;
    t_direction;
    t_independent;
    t_both;
    t_sync;
    t_outread;
    t_addr;
    t_mask;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule